// File: doc/BRIEF.md
# Floating-point status register update unit

This block keeps the floating-point status register of a processor and changes it after each floating-point operation. The arithmetic datapath is elsewhere. With each completed operation it receives the five IEEE exception flags. It can also receive a compare outcome, a selector that names one of up to four condition-code fields, and a bit that marks the compare as signalling or quiet.

For each operation the unit records the current exceptions. It then does one of two things. If an exception is raised whose trap enable is set, it posts the IEEE trap type and pulses a trap request. Otherwise it accrues the exceptions into a sticky field and writes the chosen condition field. Software loads the register through a fixed writable mask, so read-only bits keep their values. The rounding field is decoded all the time into a one-hot mode for the datapath.

Top module: `fsr_update_unit`

## Requirements
- R1: Synchronous active-low reset clears the whole register to zero. In the cycle after reset, `trap_pulse` is 0 and `rnd_onehot` is 4'b0001.
- R2: Exception flag bits are invalid=bit4, overflow=bit3, underflow=bit2, divide-by-zero=bit1, inexact=bit0. On `op_valid`, a nonzero effective flag set replaces the current-exception field at register bits [4:0].
- R3: The trap-enable field sits at bits [27:23], in the same bit order as the flags. If (effective flags AND enables) is nonzero, the next cycle shows the trap-type field at bits [16:14] = 3'b001 and `trap_pulse` = 1 for one cycle. The accrued field and the condition fields do not change.
- R4: With no trap, the effective flags are ORed into the accrued field at bits [9:5]. Accrued bits are cleared only by a load.
- R5: An operation whose effective flags are all zero leaves bits [9:0] and the trap-type field unchanged.
- R6: The compare code is equal=00, less=01, greater=10, unordered=11. When `cmp_en` is set and no trap occurs, the code is written into the field chosen by `cmp_sel`.
- R7: Condition field 0 is at bits [11:10]. Fields 1, 2 and 3 are at bits [33:32], [35:34] and [37:37+-1] = [37:36]. A compare changes no other condition field.
- R8: A signalling compare (`cmp_signal`=1) with code 11 adds invalid to the effective flags. A quiet compare with code 11 does not. The exception check happens before the condition field is written.
- R9: `rnd_onehot` decodes rounding bits [31:30] as 00 nearest-even=4'b0001, 01 toward zero=4'b0010, 10 toward +inf=4'b0100, 11 toward -inf=4'b1000.
- R10: `ld_valid` writes `ld_data` only into the writable mask 64'h0000_003F_CF80_0FFF. All other bits, including the trap type, keep their values.
- R11: When `ld_valid` and `op_valid` are both high in one cycle, only the load takes effect and `trap_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation has completed this cycle |
| exc_flags | input | 5 | IEEE flags of the operation |
| cmp_en | input | 1 | The operation is a compare |
| cmp_signal | input | 1 | 1 = signalling compare, 0 = quiet |
| cmp_rel | input | 2 | Compare outcome code |
| cmp_sel | input | 2 | Condition field to write |
| ld_valid | input | 1 | Masked register load |
| ld_data | input | 64 | Load value |
| fsr_q | output | 64 | Status register |
| trap_pulse | output | 1 | One-cycle trap request |
| rnd_onehot | output | 4 | Decoded rounding mode |

## Verification
The bench builds the block with its default parameters: a 64-bit register, four condition fields and a read-only trap-type field. These settings make the high condition fields at bits 32 to 37 reachable. They also let a check confirm that a load cannot touch the trap type. A bench reference model follows every operation, so the state carried across operations is checked: accrual over several steps, a trap with the previous accrued value kept, and signalling against quiet unordered compares under an enabled invalid trap.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      REL_EQ  = 2'b00,
      REL_LT  = 2'b01,
      REL_GT  = 2'b10,
      REL_UNO = 2'b11
   } rel_e;

   localparam logic [2:0] TRAP_IEEE = 3'b001;

   // lsb of condition field k relative to register bit 0
   function automatic int fcc_lsb(input int base, input int k);
      return (k == 0) ? base : base + 20 + 2 * k;
   endfunction
endpackage

// File: rtl/fsr_exc_unit.sv
module fsr_exc_unit #(
   parameter int N_EXC   = 5,
   parameter int INV_BIT = 4,
   parameter int FTT_W   = 3
) (
   input  logic             go,
   input  logic [N_EXC-1:0] flags,
   input  logic             cmp_en,
   input  logic             cmp_signal,
   input  logic [1:0]       cmp_rel,
   input  logic [N_EXC-1:0] cexc_c,
   input  logic [N_EXC-1:0] aexc_c,
   input  logic [N_EXC-1:0] tem_c,
   input  logic [FTT_W-1:0] ftt_c,
   output logic [N_EXC-1:0] cexc_n,
   output logic [N_EXC-1:0] aexc_n,
   output logic [FTT_W-1:0] ftt_n,
   output logic             trap
);
   import fsr_pkg::*;

   logic [N_EXC-1:0] eff;
   logic             any;

   always_comb begin
      eff = flags;
      if (cmp_en && cmp_signal && (cmp_rel == REL_UNO))
         eff[INV_BIT] = 1'b1;
      any = go && (eff != '0);
   end

   always_comb begin
      cexc_n = cexc_c;
      aexc_n = aexc_c;
      ftt_n  = ftt_c;
      trap   = 1'b0;
      if (any) begin
         cexc_n = eff;
         if ((eff & tem_c) != '0) begin
            trap  = 1'b1;
            ftt_n = FTT_W'(TRAP_IEEE);
         end else begin
            aexc_n = aexc_c | eff;
         end
      end
   end
endmodule

// File: rtl/fsr_fcc_unit.sv
module fsr_fcc_unit #(
   parameter int N_FCC = 4,
   parameter int SEL_W = 2
) (
   input  logic               go,
   input  logic [SEL_W-1:0]   sel,
   input  logic [1:0]         code,
   input  logic [2*N_FCC-1:0] fcc_c,
   output logic [2*N_FCC-1:0] fcc_n
);
   generate
      if (N_FCC == 1) begin : g_single
         assign fcc_n = go ? code : fcc_c;
      end else begin : g_multi
         for (genvar k = 0; k < N_FCC; k++) begin : g_fld
            assign fcc_n[2*k +: 2] = (go && (sel == SEL_W'(k))) ? code : fcc_c[2*k +: 2];
         end
      end
   endgenerate
endmodule

// File: rtl/fsr_rnd_decode.sv
module fsr_rnd_decode (
   input  logic [1:0] rd,
   output logic [3:0] mode
);
   always_comb begin
      unique case (rd)
         2'b00:   mode = 4'b0001;
         2'b01:   mode = 4'b0010;
         2'b10:   mode = 4'b0100;
         default: mode = 4'b1000;
      endcase
   end
endmodule

// File: rtl/fsr_update_unit.sv
module fsr_update_unit #(
   parameter int REG_W    = 64,
   parameter int N_EXC    = 5,
   parameter int INV_BIT  = 4,
   parameter int CEXC_LSB = 0,
   parameter int AEXC_OFS = 5,
   parameter int TEM_OFS  = 23,
   parameter int FCC_BASE = 10,
   parameter int N_FCC    = 4,
   parameter int FTT_LSB  = 14,
   parameter int FTT_W    = 3,
   parameter int RD_LSB   = 30,
   parameter bit LOAD_FTT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [4:0]       exc_flags,
   input  logic             cmp_en,
   input  logic             cmp_signal,
   input  logic [1:0]       cmp_rel,
   input  logic [1:0]       cmp_sel,
   input  logic             ld_valid,
   input  logic [REG_W-1:0] ld_data,
   output logic [REG_W-1:0] fsr_q,
   output logic             trap_pulse,
   output logic [3:0]       rnd_onehot
);
   import fsr_pkg::*;

   localparam int AEXC_LSB = CEXC_LSB + AEXC_OFS;
   localparam int TEM_LSB  = CEXC_LSB + TEM_OFS;
   localparam int TOP_FCC  = fcc_lsb(FCC_BASE, N_FCC - 1) + 1;

   function automatic logic [REG_W-1:0] wr_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < N_EXC; i++) begin
         m[CEXC_LSB + i] = 1'b1;
         m[AEXC_LSB + i] = 1'b1;
         m[TEM_LSB + i]  = 1'b1;
      end
      for (int k = 0; k < N_FCC; k++) begin
         m[fcc_lsb(FCC_BASE, k)]     = 1'b1;
         m[fcc_lsb(FCC_BASE, k) + 1] = 1'b1;
      end
      m[RD_LSB]     = 1'b1;
      m[RD_LSB + 1] = 1'b1;
      if (LOAD_FTT)
         for (int i = 0; i < FTT_W; i++) m[FTT_LSB + i] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] LD_MASK = wr_mask();

   generate
      if (N_EXC != 5) begin : g_bad_exc
         $error("N_EXC must be 5");
      end
      if (INV_BIT >= N_EXC) begin : g_bad_inv
         $error("INV_BIT out of range");
      end
      if (N_FCC < 1 || N_FCC > 4) begin : g_bad_fcc
         $error("N_FCC must be 1..4");
      end
      if (TOP_FCC >= REG_W || TEM_LSB + N_EXC > REG_W || RD_LSB + 2 > REG_W) begin : g_bad_w
         $error("REG_W too small for field layout");
      end
      if (FTT_W < 3) begin : g_bad_ftt
         $error("FTT_W too small");
      end
   endgenerate

   logic             go;
   logic [N_EXC-1:0] cexc_n, aexc_n;
   logic [FTT_W-1:0] ftt_n;
   logic             trap;
   logic [2*N_FCC-1:0] fcc_c, fcc_n;
   logic [REG_W-1:0] nxt;

   assign go = op_valid && !ld_valid;

   fsr_exc_unit #(
      .N_EXC(N_EXC), .INV_BIT(INV_BIT), .FTT_W(FTT_W)
   ) u_exc (
      .go         (go),
      .flags      (exc_flags[N_EXC-1:0]),
      .cmp_en     (cmp_en),
      .cmp_signal (cmp_signal),
      .cmp_rel    (cmp_rel),
      .cexc_c     (fsr_q[CEXC_LSB +: N_EXC]),
      .aexc_c     (fsr_q[AEXC_LSB +: N_EXC]),
      .tem_c      (fsr_q[TEM_LSB +: N_EXC]),
      .ftt_c      (fsr_q[FTT_LSB +: FTT_W]),
      .cexc_n     (cexc_n),
      .aexc_n     (aexc_n),
      .ftt_n      (ftt_n),
      .trap       (trap)
   );

   generate
      for (genvar k = 0; k < N_FCC; k++) begin : g_gather
         assign fcc_c[2*k +: 2] = fsr_q[fcc_lsb(FCC_BASE, k) +: 2];
      end
   endgenerate

   fsr_fcc_unit #(.N_FCC(N_FCC), .SEL_W(2)) u_fcc (
      .go    (go && cmp_en && !trap),
      .sel   (cmp_sel),
      .code  (cmp_rel),
      .fcc_c (fcc_c),
      .fcc_n (fcc_n)
   );

   always_comb begin
      nxt = fsr_q;
      if (ld_valid) begin
         nxt = (ld_data & LD_MASK) | (fsr_q & ~LD_MASK);
      end else begin
         nxt[CEXC_LSB +: N_EXC] = cexc_n;
         nxt[AEXC_LSB +: N_EXC] = aexc_n;
         nxt[FTT_LSB +: FTT_W]  = ftt_n;
         for (int k = 0; k < N_FCC; k++)
            nxt[fcc_lsb(FCC_BASE, k) +: 2] = fcc_n[2*k +: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsr_q      <= '0;
         trap_pulse <= 1'b0;
      end else begin
         fsr_q      <= nxt;
         trap_pulse <= go && trap;
      end
   end

   fsr_rnd_decode u_rnd (
      .rd   (fsr_q[RD_LSB +: 2]),
      .mode (rnd_onehot)
   );
endmodule

// File: rtl/fsr_update_chk.sv
module fsr_update_chk #(
   parameter int REG_W    = 64,
   parameter int AEXC_LSB = 5,
   parameter int FTT_LSB  = 14,
   parameter int FTT_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [4:0]       exc_flags,
   input logic             cmp_en,
   input logic             ld_valid,
   input logic [REG_W-1:0] fsr_q,
   input logic             trap_pulse,
   input logic [3:0]       rnd_onehot
);
   // R3: a trap pulse always comes with the IEEE trap type posted
   p_trap_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (fsr_q[FTT_LSB +: FTT_W] == FTT_W'(1)));

   // R3: the accrued field is held across a trap
   p_trap_keeps_aexc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (fsr_q[AEXC_LSB +: 5] == $past(fsr_q[AEXC_LSB +: 5])));

   // R4: accrued bits only clear through a load
   p_sticky_aexc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> (($past(fsr_q[AEXC_LSB +: 5]) & ~fsr_q[AEXC_LSB +: 5]) == 5'd0));

   // R5: a flag-free non-compare operation leaves the exception fields alone
   p_no_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !ld_valid && !cmp_en && exc_flags == 5'd0) |=> $stable(fsr_q[9:0]));

   // R9: exactly one rounding mode is active
   p_rnd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rnd_onehot) == 1);

   // R11: a load in the same cycle suppresses the trap
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> !trap_pulse);
endmodule

bind fsr_update_unit fsr_update_chk #(
   .REG_W(REG_W), .AEXC_LSB(AEXC_LSB), .FTT_LSB(FTT_LSB), .FTT_W(FTT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_flags(exc_flags),
   .cmp_en(cmp_en), .ld_valid(ld_valid), .fsr_q(fsr_q),
   .trap_pulse(trap_pulse), .rnd_onehot(rnd_onehot)
);

// File: tb/sim_fsr_update_unit.sv
module sim_fsr_update_unit;
   localparam logic [63:0] MASK = 64'h0000_003F_CF80_0FFF;
   localparam int NV = 12;
   // {flags[4:0], cmp_en, signal, rel[1:0], sel[1:0]}
   localparam logic [10:0] VEC [NV] = '{
      {5'b00001, 1'b0, 1'b0, 2'b00, 2'b00},
      {5'b01000, 1'b0, 1'b0, 2'b00, 2'b00},
      {5'b00000, 1'b0, 1'b0, 2'b00, 2'b00},
      {5'b00000, 1'b1, 1'b0, 2'b01, 2'b00},
      {5'b00000, 1'b1, 1'b0, 2'b10, 2'b01},
      {5'b00000, 1'b1, 1'b1, 2'b11, 2'b10},
      {5'b00000, 1'b1, 1'b0, 2'b11, 2'b11},
      {5'b00100, 1'b1, 1'b0, 2'b00, 2'b01},
      {5'b00010, 1'b0, 1'b0, 2'b00, 2'b00},
      {5'b10000, 1'b1, 1'b1, 2'b01, 2'b11},
      {5'b00000, 1'b1, 1'b0, 2'b10, 2'b00},
      {5'b11111, 1'b0, 1'b0, 2'b00, 2'b00}
   };

   logic clk = 0, rst_n = 0;
   logic op_valid = 0, cmp_en = 0, cmp_signal = 0, ld_valid = 0;
   logic [4:0] exc_flags = 0;
   logic [1:0] cmp_rel = 0, cmp_sel = 0;
   logic [63:0] ld_data = 0;
   logic [63:0] fsr_q;
   logic trap_pulse;
   logic [3:0] rnd_onehot;

   int checks = 0, errors = 0;
   logic [63:0] model = 0;
   logic model_trap = 0;

   always #4 clk = ~clk;

   fsr_update_unit u0 (.*);

   function automatic int fpos(input int k);
      return (k == 0) ? 10 : 30 + 2 * k;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference update from the requirements
   task automatic model_op(input logic [4:0] fl, input logic ce, input logic sg,
                           input logic [1:0] rl, input logic [1:0] sl);
      logic [4:0] eff;
      eff = fl;
      if (ce && sg && rl == 2'b11) eff[4] = 1'b1;
      model_trap = 0;
      if (eff != 0) begin
         model[4:0] = eff;
         if ((eff & model[27:23]) != 0) begin
            model_trap = 1;
            model[16:14] = 3'b001;
         end else model[9:5] = model[9:5] | eff;
      end
      if (ce && !model_trap) model[fpos(sl) +: 2] = rl;
   endtask

   task automatic do_op(input string req, input logic [10:0] v);
      @(negedge clk);
      {exc_flags, cmp_en, cmp_signal, cmp_rel, cmp_sel} = v;
      op_valid = 1;
      model_op(v[10:6], v[5], v[4], v[3:2], v[1:0]);
      @(negedge clk);
      op_valid = 0; cmp_en = 0; exc_flags = 0;
      chk(req, fsr_q, model);
      chk(req, 64'(trap_pulse), 64'(model_trap));
   endtask

   task automatic do_load(input logic [63:0] d);
      @(negedge clk);
      ld_valid = 1; ld_data = d;
      model = (d & MASK) | (model & ~MASK);
      model_trap = 0;
      @(negedge clk);
      ld_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset value", fsr_q, 64'd0);
      chk("R1 reset trap", 64'(trap_pulse), 64'd0);
      chk("R1 reset rnd", 64'(rnd_onehot), 64'h1);

      // R10 masked load of all ones; trap type stays read-only
      do_load('1);
      chk("R10 load all ones", fsr_q, MASK);
      chk("R10 ftt read-only", 64'(fsr_q[16:14]), 64'd0);
      do_load(64'd0);
      chk("R10 load zero", fsr_q, 64'd0);

      // table walk with traps disabled: R2 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) do_op("R2/R4/R6/R7 vector", VEC[i]);
      chk("R4 accrued all set", 64'(fsr_q[9:5]), 64'h1F);
      chk("R7 fcc3 written", 64'(fsr_q[37:36]), 64'h1);

      // R8 quiet unordered under invalid enable: no trap, fcc written
      do_load(64'h0000_0000_0800_0000);
      do_op("R8 quiet unordered", {5'b0, 1'b1, 1'b0, 2'b11, 2'b10});
      chk("R8 quiet no trap", 64'(trap_pulse), 64'd0);
      chk("R8 quiet fcc2", 64'(fsr_q[35:34]), 64'h3);
      // R3 signalling unordered traps; fcc1 kept
      do_op("R3 signalling unordered", {5'b0, 1'b1, 1'b1, 2'b11, 2'b01});
      chk("R3 trap pulse", 64'(trap_pulse), 64'd1);
      chk("R3 ftt code", 64'(fsr_q[16:14]), 64'h1);
      chk("R3 cexc invalid", 64'(fsr_q[4:0]), 64'h10);
      chk("R3 aexc kept", 64'(fsr_q[9:5]), 64'h0);
      chk("R3 fcc1 kept", 64'(fsr_q[33:32]), 64'h0);
      @(negedge clk);
      chk("R3 pulse single", 64'(trap_pulse), 64'd0);
      // R5 no-flag op after trap keeps ftt and exceptions
      do_op("R5 no flags", 11'd0);
      chk("R5 ftt kept", 64'(fsr_q[16:14]), 64'h1);
      // R10 load cannot clear ftt
      do_load(64'h0);
      chk("R10 ftt survives load", 64'(fsr_q[16:14]), 64'h1);

      // R11 load and op in same cycle
      @(negedge clk);
      ld_valid = 1; ld_data = 64'h0000_0000_0800_0003;
      op_valid = 1; exc_flags = 5'b10000;
      model = (ld_data & MASK) | (model & ~MASK);
      @(negedge clk);
      ld_valid = 0; op_valid = 0; exc_flags = 0;
      chk("R11 load wins", fsr_q, model);
      chk("R11 no trap", 64'(trap_pulse), 64'd0);

      // R9 rounding decode
      for (int r = 0; r < 4; r++) begin
         do_load(64'(r) << 30);
         chk("R9 rnd decode", 64'(rnd_onehot), 64'(4'b0001 << r));
      end

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      chk("R1 reset clears", fsr_q, 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule